// File: doc/BRIEF.md
# Two-Core Package Low-Power Sequencer

This block decides which power state a two-core package is in. Each core reports, with a one-cycle pulse, that it has executed a halt. The package drops into a low-power halt state only after every core has done so. A configuration bit selects plain Halt or a deeper Extended Halt. Extended Halt lowers the internal core ratio and then the voltage ID on the way in. On the way out it raises the voltage first and the ratio last. The bus clock itself is never touched.

While the package is in Halt, a system stop-clock request moves it into Stop-Grant. First the block raises a request for an acknowledge bus cycle. It then waits a fixed number of bus clocks after the response phase of that cycle. When stop-clock is released, the package goes back to Halt and not to Normal.

Break events wake halted cores. A break that arrives while a sequence is under way is held until the sequence finishes. Snoops are serviced in both halt states. After a system-management wake, a resume pulse can send the cores back to Halt.

Top module: `lps_seq`

## Requirements
- R1: While reset is held and at the first cycle after it, `pkg_state` is 0 (Normal), `core_halted` is 0, and `ratio_low`, `vid_low`, `ratio_req`, `vid_req`, `sg_ack_req` and `snoop_done` are 0. No break is pending. The state codes are: 0 Normal, 1 Halt, 2 ratio-down step, 3 voltage-down step, 4 Extended Halt, 5 voltage-up step, 6 ratio-up step, 7 acknowledge request, 8 delay wait, 9 Stop-Grant.
- R2: A pulse on `halt_req[c]` sets `core_halted[c]` in the next cycle. The state leaves Normal one cycle after every bit of `core_halted` is set. With only some cores halted, the state stays at Normal.
- R3: Break bits of `brk_evt` are bit0 system-management, bit1 init, bit2 NMI and bit3 INTR. Any break seen in Normal, Halt or Extended Halt clears all of `core_halted` at the next edge, and it wins over a `halt_req` in the same cycle. From Halt, the next state is Normal.
- R4: A `snoop_req` seen while the state is Halt or Extended Halt gives a one-cycle `snoop_done` pulse in the next cycle. A `snoop_req` in any other state gives no pulse.
- R5: With `xhalt_en` at 0, all-halted leads to Halt (1). With `xhalt_en` at 1, it leads to the ratio-down step (2).
- R6: On entry to Extended Halt, `ratio_low` rises with `ratio_req` in state 2 and holds until `ratio_ack`. Only then do `vid_low` and `vid_req` rise in state 3. A `vid_ack` there moves the block to state 4. `vid_low` is never 1 while `ratio_low` is 0.
- R7: A break in Extended Halt leads to state 5 with `vid_low` back at 0 and `ratio_low` still 1. After `vid_ack` comes state 6 with `ratio_low` at 0. After `ratio_ack` the block is back in Normal.
- R8: `stpclk_req` in Halt leads to state 7, where `sg_ack_req` is held until `rsp_phase`. The next state is 8, and Stop-Grant (9) is reached exactly `SG_DLY` edges after the edge that sampled `rsp_phase`.
- R9: In Stop-Grant, a low `stpclk_req` returns the block to Halt (1) at the next edge.
- R10: A break that arrives in states 2, 3 or 5 to 9 is held. It takes effect once the block is next in Normal, Halt or Extended Halt.
- R11: After a wake by a system-management break while cores were halted, a pulse on `smi_rsm` in Normal acts on `rsm_to_halt`. With `rsm_to_halt` at 1 it sets every `core_halted` bit, so the package halts again. With `rsm_to_halt` at 0 the cores stay running. An `smi_rsm` with no such prior wake has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| halt_req | input | NCORES | Per-core halt-executed pulse |
| brk_evt | input | 4 | Break events: bit0 system-management, bit1 init, bit2 NMI, bit3 INTR |
| smi_rsm | input | 1 | Pulse: return from the system-management handler |
| rsm_to_halt | input | 1 | Resume target: 1 Halt, 0 Normal |
| stpclk_req | input | 1 | Stop-clock request level |
| snoop_req | input | 1 | Snoop request pulse |
| xhalt_en | input | 1 | Use Extended Halt instead of Halt |
| rsp_phase | input | 1 | Response-phase strobe of the acknowledge cycle |
| ratio_ack | input | 1 | Core ratio change finished |
| vid_ack | input | 1 | Voltage change settled |
| pkg_state | output | 4 | Current package state code |
| core_halted | output | NCORES | Per-core halted flags |
| ratio_low | output | 1 | Low core ratio selected |
| ratio_req | output | 1 | Ratio change in progress |
| vid_low | output | 1 | Low voltage ID selected |
| vid_req | output | 1 | Voltage change in progress |
| sg_ack_req | output | 1 | Request to issue the stop-grant acknowledge cycle |
| snoop_done | output | 1 | Snoop serviced pulse |

## Verification
A snoop and a break can arrive in the same cycle. The snoop must be serviced in the halt state being left, while the break starts the exit from that state. The bench provokes this in both halt states, with each of the four break kinds. In each case it checks that `snoop_done` pulses in the next cycle and that the state has moved to Normal or to the voltage-up step. It also drives a halt request and a break together, to show that the break wins.

// File: rtl/lps_pkg.sv
package lps_pkg;

    localparam int NUM_BRK = 4;
    localparam int BRK_SMI = 0;

    typedef enum logic [3:0] {
        ST_RUN     = 4'd0,
        ST_HALT    = 4'd1,
        ST_XH_RDN  = 4'd2,
        ST_XH_VDN  = 4'd3,
        ST_XHALT   = 4'd4,
        ST_XH_VUP  = 4'd5,
        ST_XH_RUP  = 4'd6,
        ST_SG_ACK  = 4'd7,
        ST_SG_WAIT = 4'd8,
        ST_SG      = 4'd9
    } lps_state_e;

    typedef struct packed {
        lps_state_e st;
        logic       ratio_low;
        logic       vid_low;
        logic       snoop_done;
    } seq_regs_t;

endpackage

// File: rtl/lps_core_track.sv
module lps_core_track
    import lps_pkg::*;
#(
    parameter int NCORES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NCORES-1:0] halt_req,
    input  logic [NUM_BRK-1:0] brk_evt,
    input  logic              brk_open,
    input  logic              run_open,
    input  logic              smi_rsm,
    input  logic              rsm_to_halt,
    output logic [NCORES-1:0] halted,
    output logic              wake
);

    typedef struct packed {
        logic [NCORES-1:0]  halted;
        logic [NUM_BRK-1:0] pend;
        logic               smi;
    } trk_t;

    trk_t trk_d, trk_q;
    logic [NUM_BRK-1:0] evt_all;

    always_comb begin
        trk_d   = trk_q;
        evt_all = brk_evt | trk_q.pend;
        wake    = brk_open && (|evt_all);
        if (brk_open) begin
            trk_d.pend = '0;
        end else begin
            trk_d.pend = trk_q.pend | brk_evt;
        end
        if (wake) begin
            trk_d.halted = '0;
            if (evt_all[BRK_SMI] && (|trk_q.halted)) begin
                trk_d.smi = 1'b1;
            end
        end else begin
            trk_d.halted = trk_q.halted | halt_req;
            if (run_open && smi_rsm && trk_q.smi) begin
                trk_d.smi = 1'b0;
                if (rsm_to_halt) begin
                    trk_d.halted = '1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trk_q <= '0;
        end else begin
            trk_q <= trk_d;
        end
    end

    assign halted = trk_q.halted;

endmodule

// File: rtl/lps_sg_timer.sv
module lps_sg_timer #(
    parameter int SG_DLY = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic done
);

    localparam int CW = (SG_DLY < 2) ? 1 : $clog2(SG_DLY);
    localparam logic [CW-1:0] LAST = CW'(SG_DLY - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        done  = run && (cnt_q == LAST);
        cnt_d = (run && !done) ? cnt_q + 1'b1 : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/lps_seq.sv
module lps_seq
    import lps_pkg::*;
#(
    parameter int NCORES = 2,
    parameter int SG_DLY = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NCORES-1:0] halt_req,
    input  logic [3:0]        brk_evt,
    input  logic              smi_rsm,
    input  logic              rsm_to_halt,
    input  logic              stpclk_req,
    input  logic              snoop_req,
    input  logic              xhalt_en,
    input  logic              rsp_phase,
    input  logic              ratio_ack,
    input  logic              vid_ack,
    output logic [3:0]        pkg_state,
    output logic [NCORES-1:0] core_halted,
    output logic              ratio_low,
    output logic              ratio_req,
    output logic              vid_low,
    output logic              vid_req,
    output logic              sg_ack_req,
    output logic              snoop_done
);

    seq_regs_t r_d, r_q;
    logic      brk_open, run_open, wake, all_halted, sg_done;
    logic      halt_like;

    assign brk_open  = (r_q.st == ST_RUN) || (r_q.st == ST_HALT) || (r_q.st == ST_XHALT);
    assign run_open  = (r_q.st == ST_RUN);
    assign halt_like = (r_q.st == ST_HALT) || (r_q.st == ST_XHALT);

    lps_core_track #(.NCORES(NCORES)) u_track (
        .clk        (clk),
        .rst_n      (rst_n),
        .halt_req   (halt_req),
        .brk_evt    (brk_evt),
        .brk_open   (brk_open),
        .run_open   (run_open),
        .smi_rsm    (smi_rsm),
        .rsm_to_halt(rsm_to_halt),
        .halted     (core_halted),
        .wake       (wake)
    );

    lps_sg_timer #(.SG_DLY(SG_DLY)) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (r_q.st == ST_SG_WAIT),
        .done (sg_done)
    );

    assign all_halted = &core_halted;

    always_comb begin
        r_d            = r_q;
        r_d.snoop_done = snoop_req && halt_like;
        unique case (r_q.st)
            ST_RUN: begin
                if (all_halted && !wake) begin
                    if (xhalt_en) begin
                        r_d.st        = ST_XH_RDN;
                        r_d.ratio_low = 1'b1;
                    end else begin
                        r_d.st = ST_HALT;
                    end
                end
            end
            ST_HALT: begin
                if (wake) begin
                    r_d.st = ST_RUN;
                end else if (stpclk_req) begin
                    r_d.st = ST_SG_ACK;
                end
            end
            ST_XH_RDN: begin
                if (ratio_ack) begin
                    r_d.st      = ST_XH_VDN;
                    r_d.vid_low = 1'b1;
                end
            end
            ST_XH_VDN: begin
                if (vid_ack) begin
                    r_d.st = ST_XHALT;
                end
            end
            ST_XHALT: begin
                if (wake) begin
                    r_d.st      = ST_XH_VUP;
                    r_d.vid_low = 1'b0;
                end
            end
            ST_XH_VUP: begin
                if (vid_ack) begin
                    r_d.st        = ST_XH_RUP;
                    r_d.ratio_low = 1'b0;
                end
            end
            ST_XH_RUP: begin
                if (ratio_ack) begin
                    r_d.st = ST_RUN;
                end
            end
            ST_SG_ACK: begin
                if (rsp_phase) begin
                    r_d.st = ST_SG_WAIT;
                end
            end
            ST_SG_WAIT: begin
                if (sg_done) begin
                    r_d.st = ST_SG;
                end
            end
            ST_SG: begin
                if (!stpclk_req) begin
                    r_d.st = ST_HALT;
                end
            end
            default: r_d.st = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_RUN, ratio_low: 1'b0, vid_low: 1'b0, snoop_done: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign pkg_state  = r_q.st;
    assign ratio_low  = r_q.ratio_low;
    assign vid_low    = r_q.vid_low;
    assign snoop_done = r_q.snoop_done;
    assign ratio_req  = (r_q.st == ST_XH_RDN) || (r_q.st == ST_XH_RUP);
    assign vid_req    = (r_q.st == ST_XH_VDN) || (r_q.st == ST_XH_VUP);
    assign sg_ack_req = (r_q.st == ST_SG_ACK);

endmodule

// File: rtl/lps_seq_chk.sv
module lps_seq_chk
    import lps_pkg::*;
#(
    parameter int NCORES = 2,
    parameter int SG_DLY = 20
) (
    input logic              clk,
    input logic              rst_n,
    input logic [3:0]        pkg_state,
    input logic [NCORES-1:0] core_halted,
    input logic              ratio_low,
    input logic              vid_low,
    input logic              snoop_req,
    input logic              snoop_done
);

    localparam int WW = $clog2(SG_DLY + 2);
    logic [WW-1:0] wcnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wcnt <= '0;
        end else if (pkg_state == ST_SG_WAIT) begin
            wcnt <= wcnt + 1'b1;
        end else begin
            wcnt <= '0;
        end
    end

    a_r6_vid_under_ratio: assert property (@(posedge clk) disable iff (!rst_n)
        vid_low |-> ratio_low);

    a_r7_ratio_after_vid: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ratio_low) |-> (!vid_low && !$past(vid_low)));

    a_r4_snoop_in_halt: assert property (@(posedge clk) disable iff (!rst_n)
        snoop_done |-> ($past(snoop_req) &&
                        ($past(pkg_state) == ST_HALT || $past(pkg_state) == ST_XHALT)));

    a_r2_halt_needs_all: assert property (@(posedge clk) disable iff (!rst_n)
        (pkg_state != ST_RUN && $past(pkg_state) == ST_RUN) |-> $past(&core_halted));

    a_r8_wait_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (pkg_state == ST_SG_WAIT) |-> (wcnt < WW'(SG_DLY)));

    a_r8_sg_delay: assert property (@(posedge clk) disable iff (!rst_n)
        (pkg_state == ST_SG && $past(pkg_state) == ST_SG_WAIT) |-> (wcnt == WW'(SG_DLY)));

    a_r9_sg_exit_to_halt: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(pkg_state) == ST_SG && pkg_state != ST_SG) |-> (pkg_state == ST_HALT));

endmodule

bind lps_seq lps_seq_chk #(.NCORES(NCORES), .SG_DLY(SG_DLY)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pkg_state  (pkg_state),
    .core_halted(core_halted),
    .ratio_low  (ratio_low),
    .vid_low    (vid_low),
    .snoop_req  (snoop_req),
    .snoop_done (snoop_done)
);

// File: tb/test_lps_seq.sv
module test_lps_seq;

    localparam int NC  = 2;
    localparam int DLY = 20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NC-1:0] halt_req = '0;
    logic [3:0]    brk_evt = '0;
    logic          smi_rsm = 1'b0, rsm_to_halt = 1'b0, stpclk_req = 1'b0;
    logic          snoop_req = 1'b0, xhalt_en = 1'b0, rsp_phase = 1'b0;
    logic          ratio_ack = 1'b0, vid_ack = 1'b0;
    logic [3:0]    pkg_state;
    logic [NC-1:0] core_halted;
    logic          ratio_low, ratio_req, vid_low, vid_req, sg_ack_req, snoop_done;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    lps_seq #(.NCORES(NC), .SG_DLY(DLY)) i_lps_seq (
        .clk(clk), .rst_n(rst_n), .halt_req(halt_req), .brk_evt(brk_evt),
        .smi_rsm(smi_rsm), .rsm_to_halt(rsm_to_halt), .stpclk_req(stpclk_req),
        .snoop_req(snoop_req), .xhalt_en(xhalt_en), .rsp_phase(rsp_phase),
        .ratio_ack(ratio_ack), .vid_ack(vid_ack), .pkg_state(pkg_state),
        .core_halted(core_halted), .ratio_low(ratio_low), .ratio_req(ratio_req),
        .vid_low(vid_low), .vid_req(vid_req), .sg_ack_req(sg_ack_req),
        .snoop_done(snoop_done)
    );

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    // Halt both cores; lands in state 1 or 2 depending on xhalt_en.
    task automatic all_halt();
        halt_req = '1;
        step(1);
        halt_req = '0;
        step(1);
    endtask

    // Complete the Extended Halt entry, checking the ordering (R6).
    task automatic xh_enter();
        all_halt();
        check("R5 ratio-down step", pkg_state, 2);
        check("R6 ratio low first", {ratio_low, ratio_req, vid_low}, 3'b110);
        step(3);
        check("R6 wait ratio ack", pkg_state, 2);
        ratio_ack = 1'b1; step(1); ratio_ack = 1'b0;
        check("R6 voltage-down step", pkg_state, 3);
        check("R6 vid low after ratio", {ratio_low, vid_low, vid_req}, 3'b111);
        step(2);
        check("R6 wait vid ack", pkg_state, 3);
        vid_ack = 1'b1; step(1); vid_ack = 1'b0;
        check("R6 extended halt", pkg_state, 4);
    endtask

    // Finish the exit from state 5 (R7).
    task automatic xh_exit();
        check("R7 vid restored first", {vid_low, ratio_low, vid_req}, 3'b011);
        vid_ack = 1'b1; step(1); vid_ack = 1'b0;
        check("R7 ratio-up step", pkg_state, 6);
        check("R7 ratio restored", {ratio_low, ratio_req}, 2'b01);
        ratio_ack = 1'b1; step(1); ratio_ack = 1'b0;
        check("R7 back to normal", pkg_state, 0);
    endtask

    initial begin
        step(2);
        check("R1 reset state", pkg_state, 0);
        check("R1 reset outputs", {core_halted, ratio_low, ratio_req, vid_low, vid_req,
                                   sg_ack_req, snoop_done}, 0);
        rst_n = 1'b1;
        step(1);
        check("R1 after reset", pkg_state, 0);

        // R2: one core halted leaves package in Normal
        halt_req = 2'b01; step(1); halt_req = '0; step(2);
        check("R2 one core halted", core_halted, 1);
        check("R2 stays normal", pkg_state, 0);
        // R4: snoop in Normal not acknowledged
        snoop_req = 1'b1; step(1); snoop_req = 1'b0;
        check("R4 no snoop ack in normal", snoop_done, 0);
        // R3: break beats simultaneous halt request
        halt_req = 2'b10; brk_evt = 4'b0010; step(1);
        halt_req = '0; brk_evt = '0;
        check("R3 break priority", core_halted, 0);
        step(1);
        check("R3 still normal", pkg_state, 0);

        // Sweep: both halt kinds x every break kind, snoop and break together
        for (int x = 0; x < 2; x++) begin
            for (int b = 0; b < 4; b++) begin
                xhalt_en = x[0];
                if (x == 0) begin
                    all_halt();
                    check("R5 plain halt", pkg_state, 1);
                end else begin
                    xh_enter();
                end
                snoop_req = 1'b1; brk_evt = 4'(1 << b); step(1);
                snoop_req = 1'b0; brk_evt = '0;
                check("R4 snoop ack in halt", snoop_done, 1);
                check("R3 cores released", core_halted, 0);
                check("R3 R7 wake target", pkg_state, (x == 0) ? 0 : 5);
                step(1);
                check("R4 single pulse", snoop_done, 0);
                if (x == 1) xh_exit();
                if (b == 0) begin
                    rsm_to_halt = (x == 0); smi_rsm = 1'b1; step(1); smi_rsm = 1'b0;
                    check("R11 resume target", core_halted, (x == 0) ? 3 : 0);
                    step(1);
                    check("R11 resume state", pkg_state, (x == 0) ? 1 : 0);
                    if (x == 0) begin
                        brk_evt = 4'b1000; step(1); brk_evt = '0; step(1);
                        check("R3 wake after resume", pkg_state, 0);
                    end
                end else if (b == 3) begin
                    rsm_to_halt = 1'b1; smi_rsm = 1'b1; step(1); smi_rsm = 1'b0;
                    step(1);
                    check("R11 resume without smi ignored", {pkg_state, core_halted}, 0);
                end
                step(1);
            end
        end

        // R8 / R9 / R10: stop-grant path with a break held across it
        xhalt_en = 1'b0;
        all_halt();
        stpclk_req = 1'b1; step(1);
        check("R8 ack request state", pkg_state, 7);
        check("R8 ack request out", sg_ack_req, 1);
        step(4);
        check("R8 holds until response", {pkg_state, sg_ack_req}, {4'd7, 1'b1});
        rsp_phase = 1'b1; step(1); rsp_phase = 1'b0;
        check("R8 delay wait", pkg_state, 8);
        brk_evt = 4'b0100; step(1); brk_evt = '0;
        check("R10 break held in wait", core_halted, 3);
        step(DLY - 2);
        check("R8 not early", pkg_state, 8);
        step(1);
        check("R8 stop-grant after delay", pkg_state, 9);
        step(3);
        check("R9 stays while stop-clock", pkg_state, 9);
        stpclk_req = 1'b0; step(1);
        check("R9 return to halt", pkg_state, 1);
        step(1);
        check("R10 held break wakes", {pkg_state, core_halted}, 0);

        // R10: break during extended-halt entry
        xhalt_en = 1'b1;
        all_halt();
        brk_evt = 4'b0001; step(1); brk_evt = '0;
        ratio_ack = 1'b1; step(1); ratio_ack = 1'b0;
        vid_ack = 1'b1; step(1); vid_ack = 1'b0;
        check("R10 reaches extended halt", pkg_state, 4);
        step(1);
        check("R10 held break exits", pkg_state, 5);
        xh_exit();
        smi_rsm = 1'b1; rsm_to_halt = 1'b0; step(1); smi_rsm = 1'b0;

        // R1: reset in the middle of Extended Halt
        xh_enter();
        rst_n = 1'b0; step(1);
        check("R1 reset mid-sequence", {pkg_state, ratio_low, vid_low, core_halted}, 0);
        rst_n = 1'b1; step(2);
        check("R1 no pending after reset", pkg_state, 0);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
            $finish;
        end
    end

endmodule